// File: doc/BRIEF.md
# Attention interrupt mask controller

This block turns the attention flags of a block-transfer host interface into one level-sensitive interrupt toward the host. It keeps a small mask register that has two live bits. One bit is an interrupt enable that the host controls. The other is a pending bit that the host reads and can acknowledge. The host writes this register directly. The message engine signals when a response is ready. The management controller sets or clears its system-management attention flag through requests, and that flag is held in this block. A global interrupt-enable input and a use-interrupt strap decide whether responses and attention may assert the line.

The interrupt output is the registered pending bit, so it never glitches. More than one event can arrive in the same clock cycle. They are then applied in a fixed order: first the host register write, then the response event, then the attention request. Each stage sees the result of the stage before it. A reset request in a cycle overrides every other event in that cycle. A cold reset drops the enable and pending bits. A warm reset keeps them.

Top module: `atn_irq_mask`

## Requirements
- R1: Mask readback places the enable at bit 0 and the pending bit at bit 1, and all other bits read 0. The interrupt output equals the pending bit (active-high by default).
- R2: A host write that moves enable from 0 to 1 sets pending when response attention or system-management attention is set. With neither set, it only sets enable.
- R3: A host write that moves enable from 1 to 0 clears both enable and pending.
- R4: A host write with bit 1 at 1 clears a set pending bit. A 0 in bit 1 leaves pending unchanged.
- R5: A response-ready pulse sets pending only when the strap, the global enable and the mask enable are all 1.
- R6: A request that sets system-management attention always sets the flag. It sets pending only if its raise flag, the strap, the global enable and the mask enable are all 1 and response attention is 0.
- R7: An attention request whose value equals the current flag changes nothing.
- R8: A request that clears system-management attention clears the flag. It clears pending only when response attention is 0.
- R9: A cold reset request clears enable and pending. A warm reset request leaves them unchanged. Either kind discards every other event in the same cycle, and neither touches the attention flag.
- R10: Events in one cycle apply in order: host write, then response, then attention request. Each one sees the state left by the one before.
- R11: After the asynchronous reset, the mask reads 0, the interrupt is low and the attention flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_mask_we | input | 1 | Host write strobe for the mask register |
| host_mask_wdata | input | REG_W | Host write data |
| host_mask_rdata | output | REG_W | Mask register readback |
| rsp_ready | input | 1 | Response-ready pulse from the message engine |
| sms_req | input | 1 | Attention set/clear request strobe |
| sms_val | input | 1 | Requested attention value |
| sms_raise | input | 1 | Request may raise the interrupt |
| resp_atn | input | 1 | Controller-to-host response attention flag |
| glb_irq_en | input | 1 | Global interrupt enable |
| irq_strap | input | 1 | Use-interrupt strap |
| rst_req | input | 1 | Interface reset request |
| rst_cold | input | 1 | Reset request is cold (1) or warm (0) |
| sms_atn | output | 1 | System-management attention flag |
| irq | output | 1 | Host interrupt line |

## Verification
The hard cases are several events landing in the same cycle. One example is a write that disables the interrupt together with a response pulse. Another is clearing the attention flag while response attention is still set and pending is held. Directed sequences cannot easily reach all of these combinations. A pseudo-random sweep therefore drives every event input each cycle and checks the outputs against an ordered bench model. Directed steps first put the block into each pending and enable state and then apply the corner cases of each requirement.

// File: rtl/atn_irq_mask_pkg.sv
package atn_irq_mask_pkg;
   typedef struct packed {
      logic en;
      logic pend;
   } mask_st_t;

   localparam mask_st_t MASK_ST_IDLE = '{en: 1'b0, pend: 1'b0};
endpackage

// File: rtl/atn_irq_host_wr.sv
module atn_irq_host_wr
   import atn_irq_mask_pkg::*;
(
   input  mask_st_t st_i,
   input  logic     we,
   input  logic     wr_en_bit,
   input  logic     wr_pend_bit,
   input  logic     atn_any,
   output mask_st_t st_o
);
   always_comb begin
      st_o = st_i;
      if (we) begin
         if (wr_en_bit != st_i.en) begin
            if (wr_en_bit) begin
               if (atn_any) st_o.pend = 1'b1;
               st_o.en = 1'b1;
            end else begin
               st_o.pend = 1'b0;
               st_o.en   = 1'b0;
            end
         end
         if (wr_pend_bit && st_o.pend) st_o.pend = 1'b0;
      end
   end
endmodule

// File: rtl/atn_irq_rsp_stage.sv
module atn_irq_rsp_stage
   import atn_irq_mask_pkg::*;
(
   input  mask_st_t st_i,
   input  logic     rsp,
   input  logic     gate,
   output mask_st_t st_o
);
   always_comb begin
      st_o = st_i;
      if (rsp && gate && st_i.en && !st_i.pend) st_o.pend = 1'b1;
   end
endmodule

// File: rtl/atn_irq_sms_stage.sv
module atn_irq_sms_stage
   import atn_irq_mask_pkg::*;
(
   input  mask_st_t st_i,
   input  logic     sms_i,
   input  logic     req,
   input  logic     val,
   input  logic     raise,
   input  logic     gate,
   input  logic     resp_atn,
   output mask_st_t st_o,
   output logic     sms_o
);
   always_comb begin
      st_o  = st_i;
      sms_o = sms_i;
      if (req && (val != sms_i)) begin
         sms_o = val;
         if (val) begin
            if (raise && gate && !resp_atn && st_i.en) st_o.pend = 1'b1;
         end else if (!resp_atn && st_i.pend) begin
            st_o.pend = 1'b0;
         end
      end
   end
endmodule

// File: rtl/atn_irq_mask.sv
module atn_irq_mask
   import atn_irq_mask_pkg::*;
#(
   parameter int unsigned REG_W        = 8,
   parameter int unsigned EN_BIT       = 0,
   parameter int unsigned PEND_BIT     = 1,
   parameter bit          IRQ_ACT_HIGH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_mask_we,
   input  logic [REG_W-1:0] host_mask_wdata,
   output logic [REG_W-1:0] host_mask_rdata,
   input  logic             rsp_ready,
   input  logic             sms_req,
   input  logic             sms_val,
   input  logic             sms_raise,
   input  logic             resp_atn,
   input  logic             glb_irq_en,
   input  logic             irq_strap,
   input  logic             rst_req,
   input  logic             rst_cold,
   output logic             sms_atn,
   output logic             irq
);
   localparam int unsigned MIN_W = ((EN_BIT > PEND_BIT) ? EN_BIT : PEND_BIT) + 1;

   if (REG_W < MIN_W) begin : g_bad_width
      $error("atn_irq_mask: REG_W too small for the bit positions");
   end
   if (EN_BIT == PEND_BIT) begin : g_bad_pos
      $error("atn_irq_mask: enable and pending bits must differ");
   end

   mask_st_t st_q, st_wr, st_rsp, st_sms, st_d;
   logic     sms_q, sms_nx, sms_d;
   logic     gate;
   logic     unused_wbits;

   assign gate         = irq_strap & glb_irq_en;
   assign unused_wbits = ^host_mask_wdata;

   atn_irq_host_wr u_host_wr (
      .st_i        (st_q),
      .we          (host_mask_we),
      .wr_en_bit   (host_mask_wdata[EN_BIT]),
      .wr_pend_bit (host_mask_wdata[PEND_BIT]),
      .atn_any     (resp_atn | sms_q),
      .st_o        (st_wr)
   );

   atn_irq_rsp_stage u_rsp (
      .st_i (st_wr),
      .rsp  (rsp_ready),
      .gate (gate),
      .st_o (st_rsp)
   );

   atn_irq_sms_stage u_sms (
      .st_i     (st_rsp),
      .sms_i    (sms_q),
      .req      (sms_req),
      .val      (sms_val),
      .raise    (sms_raise),
      .gate     (gate),
      .resp_atn (resp_atn),
      .st_o     (st_sms),
      .sms_o    (sms_nx)
   );

   always_comb begin
      st_d  = st_sms;
      sms_d = sms_nx;
      if (rst_req) begin
         sms_d = sms_q;
         st_d  = rst_cold ? MASK_ST_IDLE : st_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= MASK_ST_IDLE;
         sms_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         sms_q <= sms_d;
      end
   end

   for (genvar b = 0; b < REG_W; b++) begin : g_rd
      if (b == EN_BIT) begin : g_en
         assign host_mask_rdata[b] = st_q.en;
      end else if (b == PEND_BIT) begin : g_pend
         assign host_mask_rdata[b] = st_q.pend;
      end else begin : g_zero
         assign host_mask_rdata[b] = 1'b0;
      end
   end

   if (IRQ_ACT_HIGH) begin : g_irq_hi
      assign irq = st_q.pend;
   end else begin : g_irq_lo
      assign irq = ~st_q.pend;
   end

   assign sms_atn = sms_q;
endmodule

// File: rtl/atn_irq_mask_chk.sv
module atn_irq_mask_chk #(
   parameter int unsigned REG_W        = 8,
   parameter int unsigned EN_BIT       = 0,
   parameter int unsigned PEND_BIT     = 1,
   parameter bit          IRQ_ACT_HIGH = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_mask_we,
   input logic [REG_W-1:0] host_mask_wdata,
   input logic [REG_W-1:0] host_mask_rdata,
   input logic             rsp_ready,
   input logic             sms_req,
   input logic             sms_val,
   input logic             resp_atn,
   input logic             glb_irq_en,
   input logic             irq_strap,
   input logic             rst_req,
   input logic             rst_cold,
   input logic             sms_atn,
   input logic             irq
);
   logic en, pend;
   assign en   = host_mask_rdata[EN_BIT];
   assign pend = host_mask_rdata[PEND_BIT];

   p_irq_follows_pend_r1: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (IRQ_ACT_HIGH ? pend : !pend));

   p_other_bits_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(host_mask_rdata) == $countones({en, pend}));

   p_pend_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pend |-> en);

   p_disable_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_mask_we && en && !host_mask_wdata[EN_BIT] && !rst_req) |=> (!en && !pend));

   p_rsp_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_ready && !(irq_strap && glb_irq_en) && !pend && !host_mask_we && !sms_req && !rst_req)
      |=> !pend);

   p_sms_same_noop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sms_req && (sms_val == sms_atn) && !host_mask_we && !rsp_ready && !rst_req)
      |=> ($stable(host_mask_rdata) && $stable(sms_atn)));

   p_sms_clr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sms_req && !sms_val && sms_atn && resp_atn && pend && !host_mask_we && !rst_req)
      |=> pend);

   p_cold_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req && rst_cold) |=> (!en && !pend));

   p_warm_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_req && !rst_cold) |=> ($stable(host_mask_rdata) && $stable(sms_atn)));
endmodule

bind atn_irq_mask atn_irq_mask_chk #(
   .REG_W(REG_W), .EN_BIT(EN_BIT), .PEND_BIT(PEND_BIT), .IRQ_ACT_HIGH(IRQ_ACT_HIGH)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .host_mask_we    (host_mask_we),
   .host_mask_wdata (host_mask_wdata),
   .host_mask_rdata (host_mask_rdata),
   .rsp_ready       (rsp_ready),
   .sms_req         (sms_req),
   .sms_val         (sms_val),
   .resp_atn        (resp_atn),
   .glb_irq_en      (glb_irq_en),
   .irq_strap       (irq_strap),
   .rst_req         (rst_req),
   .rst_cold        (rst_cold),
   .sms_atn         (sms_atn),
   .irq             (irq)
);

// File: tb/atn_irq_mask_bench.sv
module atn_irq_mask_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         we = 1'b0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] rdata;
   logic         rsp = 1'b0, sreq = 1'b0, sval = 1'b0, sraise = 1'b0;
   logic         ratn = 1'b0, glb = 1'b0, strap = 1'b0, rreq = 1'b0, rcold = 1'b0;
   logic         sms, irq;

   int total = 0;
   int bad   = 0;

   logic m_en = 1'b0, m_pend = 1'b0, m_sms = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   atn_irq_mask u_atn_irq_mask (
      .clk(clk), .rst_n(rst_n), .host_mask_we(we), .host_mask_wdata(wdata),
      .host_mask_rdata(rdata), .rsp_ready(rsp), .sms_req(sreq), .sms_val(sval),
      .sms_raise(sraise), .resp_atn(ratn), .glb_irq_en(glb), .irq_strap(strap),
      .rst_req(rreq), .rst_cold(rcold), .sms_atn(sms), .irq(irq)
   );

   task automatic model_update();
      logic e, p, s, g;
      e = m_en; p = m_pend; s = m_sms; g = strap & glb;
      if (rreq) begin
         if (rcold) begin e = 1'b0; p = 1'b0; end
      end else begin
         if (we) begin
            if (wdata[0] != e) begin
               if (wdata[0]) begin if (ratn | s) p = 1'b1; e = 1'b1; end
               else begin p = 1'b0; e = 1'b0; end
            end
            if (wdata[1] && p) p = 1'b0;
         end
         if (rsp && g && e && !p) p = 1'b1;
         if (sreq && sval != s) begin
            s = sval;
            if (sval) begin
               if (sraise && g && !ratn && e) p = 1'b1;
            end else if (!ratn && p) p = 1'b0;
         end
      end
      m_en = e; m_pend = p; m_sms = s;
   endtask

   task automatic check(input string tag);
      logic [W-1:0] exp_rd;
      exp_rd = {{(W-2){1'b0}}, m_pend, m_en};
      total++;
      if (rdata !== exp_rd || irq !== m_pend || sms !== m_sms) begin
         bad++;
         $display("FAIL %s: rdata=%h irq=%b sms=%b expected rdata=%h irq=%b sms=%b",
                  tag, rdata, irq, sms, exp_rd, m_pend, m_sms);
      end
   endtask

   task automatic idle();
      we = 1'b0; wdata = '0; rsp = 1'b0; sreq = 1'b0; sval = 1'b0;
      sraise = 1'b0; rreq = 1'b0; rcold = 1'b0;
   endtask

   task automatic step(input string tag);
      @(posedge clk);
      model_update();
      @(negedge clk);
      check(tag);
      idle();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      total++; bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] r;
      r = 32'h1234_5678;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1 check("R11 reset state");
      glb = 1'b1; strap = 1'b1;

      // R2: enable with no attention
      we = 1'b1; wdata = 8'h01; step("R2 enable no atn");
      // disable, then enable with response attention present
      we = 1'b1; wdata = 8'h00; step("R3 disable idle");
      ratn = 1'b1; we = 1'b1; wdata = 8'h01; step("R2 enable with atn");
      // R4: write 0 to pend keeps, 1 clears
      we = 1'b1; wdata = 8'h01; step("R4 pend write 0 keeps");
      we = 1'b1; wdata = 8'h03; step("R4 pend write 1 clears");
      ratn = 1'b0;
      // R5 gating
      glb = 1'b0; rsp = 1'b1; step("R5 rsp global off");
      glb = 1'b1; strap = 1'b0; rsp = 1'b1; step("R5 rsp strap off");
      strap = 1'b1; rsp = 1'b1; step("R5 rsp raises");
      step("R1 readback and irq");
      // R3 disable clears pending
      we = 1'b1; wdata = 8'h00; step("R3 disable clears pend");
      // R6: set blocked by response attention
      we = 1'b1; wdata = 8'h01; step("R2 re-enable");
      ratn = 1'b1; sreq = 1'b1; sval = 1'b1; sraise = 1'b1; step("R6 set blocked by resp atn");
      ratn = 1'b0;
      sreq = 1'b1; sval = 1'b1; sraise = 1'b1; step("R7 repeat set no effect");
      sreq = 1'b1; sval = 1'b0; step("R8 clear with pend 0");
      sreq = 1'b1; sval = 1'b1; sraise = 1'b0; step("R6 set without raise");
      sreq = 1'b1; sval = 1'b0; step("R8 clear flag");
      sreq = 1'b1; sval = 1'b1; sraise = 1'b1; step("R6 set raises");
      ratn = 1'b1; sreq = 1'b1; sval = 1'b0; step("R8 clear keeps pend with resp atn");
      ratn = 1'b0; sreq = 1'b1; sval = 1'b1; sraise = 1'b1; step("R6 set again with pend");
      sreq = 1'b1; sval = 1'b0; step("R8 clear lowers line");
      // R9 resets
      rsp = 1'b1; step("R5 rsp raise before reset");
      rreq = 1'b1; rcold = 1'b0; we = 1'b1; wdata = 8'h00; step("R9 warm keeps and masks events");
      rreq = 1'b1; rcold = 1'b1; sreq = 1'b1; sval = 1'b1; step("R9 cold clears");
      // R10 ordering
      we = 1'b1; wdata = 8'h01; rsp = 1'b1; step("R10 enable then rsp same cycle");
      we = 1'b1; wdata = 8'h00; rsp = 1'b1; step("R10 disable beats rsp");
      ratn = 1'b0;
      // sweep
      for (int i = 0; i < 4000; i++) begin
         r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
         we = r[0] & r[1]; wdata = r[15:8]; rsp = r[2];
         sreq = r[3] & r[4]; sval = r[5]; sraise = r[6]; ratn = r[7];
         glb = r[16] | r[17]; strap = r[18] | r[19];
         rreq = (r[23:20] == 4'd0); rcold = r[24];
         step("R10 sweep");
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule